// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

A synchronous 2048-word by 9-bit memory with two fully independent ports, a left one and a right one. Each port has its own active-low chip enable, active-low output enable, a read/write select (high reads, low writes), an 11-bit address, a 9-bit write bus and a registered 9-bit read bus. Either port may read or write any word in any cycle.

The two highest words double as mailboxes. Word 0x7FE belongs to the left port and word 0x7FF to the right port. When one port writes the other port's mailbox, an active-low interrupt is raised toward the owner. The owner drops its interrupt by accessing its own mailbox with chip enable and output enable both low. The 9-bit mailbox contents are ordinary data whose meaning is up to the user. A parameter turns the mailbox feature off; the two words are then plain storage and the interrupts stay idle.

Top module: `dpm_mailbox_ram`

## Requirements
- R1: While reset is applied and at the first cycle after it, both interrupt outputs are high (inactive) and both read buses are zero.
- R2: A port with chip enable low and read/write low stores its write data at its address on the clock edge; a port with chip enable low and read/write high presents the word at its address on its read bus after that edge. Both ports reach all 2048 words.
- R3: With mailboxes enabled, a right-port write (chip enable low, read/write low) to address 0x7FE drives the left interrupt output low from the next clock edge.
- R4: With mailboxes enabled, a left-port write to address 0x7FF drives the right interrupt output low from the next clock edge.
- R5: The left interrupt returns high after an edge at which the left port has chip enable low, output enable low and address 0x7FE, whatever its read/write level; with output enable high the same access leaves the interrupt as it is.
- R6: The right interrupt returns high after an edge at which the right port has chip enable low, output enable low and address 0x7FF, whatever its read/write level; with output enable high it stays as it is.
- R7: When a set and a clear of the same interrupt happen at the same edge, the interrupt ends low.
- R8: A port whose chip enable is high writes nothing, keeps its read bus unchanged, and neither sets nor clears any interrupt.
- R9: A mailbox word written by one port reads back unchanged from either port.
- R10: With mailboxes disabled, both interrupt outputs stay high and 0x7FE and 0x7FF store and return data like any other word.
- R11: A port writing its own mailbox, or any port writing an address other than the other port's mailbox, leaves the interrupt outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_l_n | input | 1 | Left chip enable, active low |
| oe_l_n | input | 1 | Left output enable, active low |
| rw_l_n | input | 1 | Left read (1) or write (0) |
| addr_l | input | 11 | Left address |
| wdata_l | input | 9 | Left write data |
| rdata_l | output | 9 | Left registered read data |
| int_l_n | output | 1 | Interrupt toward the left port, active low |
| ce_r_n | input | 1 | Right chip enable, active low |
| oe_r_n | input | 1 | Right output enable, active low |
| rw_r_n | input | 1 | Right read (1) or write (0) |
| addr_r | input | 11 | Right address |
| wdata_r | input | 9 | Right write data |
| rdata_r | output | 9 | Right registered read data |
| int_r_n | output | 1 | Interrupt toward the right port, active low |

## Verification
The bench writes every word from one port and reads it back from the other, in both directions, with address-dependent patterns, so a stuck address bit or a crossed port shows as wrong data, and the mailbox flags are checked after each sweep to catch a design that raises a flag on the writer's own mailbox or on reads. It then drives a clear with output enable high (a design ignoring output enable would drop the flag), a clear done as a write (a design requiring a read would keep it), and a set and clear at the same edge (a clear-priority design would end inactive). Deselected ports carrying write and clear patterns must change neither memory nor flags, and a second instance with mailboxes disabled, fed the same stimulus, must keep its flags idle while returning the same data.

// File: rtl/dpm_pkg.sv
// Package dpm_pkg
// Shared types for the dual-port mailbox RAM. Assumes one request record
// per port, produced by the port decoder and consumed by storage and flags.
package dpm_pkg;

    // Decoded per-port request, all fields active high.
    typedef struct packed {
        logic wr;        // store write data this edge
        logic rd;        // capture read data this edge
        logic clr_own;   // access to own mailbox that clears own flag
        logic set_peer;  // write to the other port's mailbox
    } port_req_t;

endpackage

// File: rtl/dpm_port_dec.sv
// Module dpm_port_dec
// Turns one port's active-low controls into a request record. Assumes the
// mailbox addresses are fixed by the parent; with MBOX_EN at 0 the mailbox
// fields are tied off so the words behave as ordinary storage.
module dpm_port_dec
    import dpm_pkg::*;
#(
    parameter int              ADDR_W    = 11,
    parameter logic [ADDR_W-1:0] OWN_MBOX  = '1,
    parameter logic [ADDR_W-1:0] PEER_MBOX = '0,
    parameter bit              MBOX_EN   = 1'b1
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              rw_n,
    input  logic [ADDR_W-1:0] addr,
    output port_req_t         req
);

    logic sel;
    assign sel = !ce_n;

    // Plain memory access decode.
    always_comb begin
        req.wr = sel && !rw_n;
        req.rd = sel && rw_n;
    end

    generate
        if (MBOX_EN) begin : g_mbox
            // Mailbox decode: clear ignores read/write, set needs a write.
            always_comb begin
                req.clr_own  = sel && !oe_n && (addr == OWN_MBOX);
                req.set_peer = sel && !rw_n && (addr == PEER_MBOX);
            end
        end else begin : g_plain
            // Mailbox feature absent: no flag traffic at all.
            always_comb begin
                req.clr_own  = 1'b0;
                req.set_peer = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/dpm_store.sv
// Module dpm_store
// Two-port synchronous word store with registered read buses. Assumes a
// port never reads and writes in the same cycle; a read of a word the other
// port writes at the same edge returns the old word. If both ports write
// one word at one edge, the right port's data is kept.
module dpm_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_l,
    input  logic              rd_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [DATA_W-1:0] wdata_l,
    output logic [DATA_W-1:0] rdata_l,
    input  logic              wr_r,
    input  logic              rd_r,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [DATA_W-1:0] wdata_r,
    output logic [DATA_W-1:0] rdata_r
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Array update from both ports.
    always_ff @(posedge clk) begin
        if (wr_l) mem[addr_l] <= wdata_l;
        if (wr_r) mem[addr_r] <= wdata_r;
    end

    // Left read register, held while no read is issued.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_l <= '0;
        else if (rd_l) rdata_l <= mem[addr_l];
    end

    // Right read register, held while no read is issued.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_r <= '0;
        else if (rd_r) rdata_r <= mem[addr_r];
    end

endmodule

// File: rtl/dpm_mbox_flag.sv
// Module dpm_mbox_flag
// One registered active-low mailbox interrupt. Assumes set and clear are
// single-cycle strobes; set takes priority when both arrive together.
module dpm_mbox_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq_n
);

    // Flag state: reset inactive, set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   irq_n <= 1'b1;
        else if (set) irq_n <= 1'b0;
        else if (clr) irq_n <= 1'b1;
    end

endmodule

// File: rtl/dpm_mailbox_ram.sv
// Module dpm_mailbox_ram
// Dual-port RAM with a mailbox interrupt per port. The two top words are
// the mailboxes: DEPTH-2 for the left port, DEPTH-1 for the right port.
// Assumes address collisions are resolved outside this block.
module dpm_mailbox_ram
    import dpm_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int DATA_W  = 9,
    parameter bit MBOX_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_l_n,
    input  logic              oe_l_n,
    input  logic              rw_l_n,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [DATA_W-1:0] wdata_l,
    output logic [DATA_W-1:0] rdata_l,
    output logic              int_l_n,
    input  logic              ce_r_n,
    input  logic              oe_r_n,
    input  logic              rw_r_n,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [DATA_W-1:0] wdata_r,
    output logic [DATA_W-1:0] rdata_r,
    output logic              int_r_n
);

    localparam int                DEPTH  = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] MBOX_L = ADDR_W'(DEPTH - 2);
    localparam logic [ADDR_W-1:0] MBOX_R = ADDR_W'(DEPTH - 1);
    localparam int                NPORT  = 2;

    // Index 0 is the left port, index 1 the right port.
    logic              ce_v   [NPORT];
    logic              oe_v   [NPORT];
    logic              rw_v   [NPORT];
    logic [ADDR_W-1:0] addr_v [NPORT];
    port_req_t         req    [NPORT];
    logic              irq_v  [NPORT];

    // Gather port pins into arrays for the per-port generate.
    always_comb begin
        ce_v[0] = ce_l_n;  oe_v[0] = oe_l_n;  rw_v[0] = rw_l_n;  addr_v[0] = addr_l;
        ce_v[1] = ce_r_n;  oe_v[1] = oe_r_n;  rw_v[1] = rw_r_n;  addr_v[1] = addr_r;
    end

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            localparam logic [ADDR_W-1:0] OWN  = (p == 0) ? MBOX_L : MBOX_R;
            localparam logic [ADDR_W-1:0] PEER = (p == 0) ? MBOX_R : MBOX_L;

            dpm_port_dec #(
                .ADDR_W   (ADDR_W),
                .OWN_MBOX (OWN),
                .PEER_MBOX(PEER),
                .MBOX_EN  (MBOX_EN)
            ) u_dec (
                .ce_n(ce_v[p]),
                .oe_n(oe_v[p]),
                .rw_n(rw_v[p]),
                .addr(addr_v[p]),
                .req (req[p])
            );

            // Flag toward port p is set by the other port, cleared by p.
            dpm_mbox_flag u_flag (
                .clk  (clk),
                .rst_n(rst_n),
                .set  (req[NPORT-1-p].set_peer),
                .clr  (req[p].clr_own),
                .irq_n(irq_v[p])
            );
        end
    endgenerate

    assign int_l_n = irq_v[0];
    assign int_r_n = irq_v[1];

    dpm_store #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_l   (req[0].wr),
        .rd_l   (req[0].rd),
        .addr_l (addr_l),
        .wdata_l(wdata_l),
        .rdata_l(rdata_l),
        .wr_r   (req[1].wr),
        .rd_r   (req[1].rd),
        .addr_r (addr_r),
        .wdata_r(wdata_r),
        .rdata_r(rdata_r)
    );

endmodule

// File: rtl/dpm_mailbox_chk.sv
// Module dpm_mailbox_chk
// Port-level properties of the mailbox RAM, bound onto every instance.
// Assumes the mailbox addresses are the two top words.
module dpm_mailbox_chk #(
    parameter int ADDR_W  = 11,
    parameter int DATA_W  = 9,
    parameter bit MBOX_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_l_n,
    input logic              oe_l_n,
    input logic              rw_l_n,
    input logic [ADDR_W-1:0] addr_l,
    input logic [DATA_W-1:0] rdata_l,
    input logic              int_l_n,
    input logic              ce_r_n,
    input logic              oe_r_n,
    input logic              rw_r_n,
    input logic [ADDR_W-1:0] addr_r,
    input logic [DATA_W-1:0] rdata_r,
    input logic              int_r_n
);

    localparam logic [ADDR_W-1:0] BOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};

    logic hit_set_l, hit_set_r, hit_clr_l, hit_clr_r;
    assign hit_set_l = MBOX_EN && !ce_r_n && !rw_r_n && (addr_r == BOX_L);
    assign hit_set_r = MBOX_EN && !ce_l_n && !rw_l_n && (addr_l == BOX_R);
    assign hit_clr_l = MBOX_EN && !ce_l_n && !oe_l_n && (addr_l == BOX_L);
    assign hit_clr_r = MBOX_EN && !ce_r_n && !oe_r_n && (addr_r == BOX_R);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (int_l_n && int_r_n && rdata_l == '0 && rdata_r == '0)); // R1
    AST_SET_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set_l |=> !int_l_n); // R3
    AST_SET_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set_r |=> !int_r_n); // R4
    AST_CLR_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_clr_l && !hit_set_l) |=> int_l_n); // R5
    AST_CLR_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_clr_r && !hit_set_r) |=> int_r_n); // R6
    AST_HOLD_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_set_l && !hit_clr_l) |=> $stable(int_l_n)); // R11
    AST_HOLD_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_set_r && !hit_clr_r) |=> $stable(int_r_n)); // R11
    AST_IDLE_RDATA_L: assert property (@(posedge clk) disable iff (!rst_n)
        ce_l_n |=> $stable(rdata_l)); // R8
    AST_IDLE_RDATA_R: assert property (@(posedge clk) disable iff (!rst_n)
        ce_r_n |=> $stable(rdata_r)); // R8
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !MBOX_EN |-> (int_l_n && int_r_n)); // R10

endmodule

bind dpm_mailbox_ram dpm_mailbox_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MBOX_EN(MBOX_EN)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_l_n (ce_l_n),
    .oe_l_n (oe_l_n),
    .rw_l_n (rw_l_n),
    .addr_l (addr_l),
    .rdata_l(rdata_l),
    .int_l_n(int_l_n),
    .ce_r_n (ce_r_n),
    .oe_r_n (oe_r_n),
    .rw_r_n (rw_r_n),
    .addr_r (addr_r),
    .rdata_r(rdata_r),
    .int_r_n(int_r_n)
);

// File: tb/tb_dpm_mailbox_ram.sv
// Bench for dpm_mailbox_ram: full-array sweeps in both directions plus
// mailbox corner cases, on a mailbox instance and a plain instance.
module tb_dpm_mailbox_ram;

    localparam int AW    = 11;
    localparam int DW    = 9;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] BOX_L = 11'h7FE;
    localparam logic [AW-1:0] BOX_R = 11'h7FF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_l_n = 1'b1, oe_l_n = 1'b1, rw_l_n = 1'b1;
    logic          ce_r_n = 1'b1, oe_r_n = 1'b1, rw_r_n = 1'b1;
    logic [AW-1:0] addr_l = '0, addr_r = '0;
    logic [DW-1:0] wdata_l = '0, wdata_r = '0;
    logic [DW-1:0] rdata_l, rdata_r, off_rdata_l, off_rdata_r;
    logic          int_l_n, int_r_n, off_int_l_n, off_int_r_n;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] held;

    always #2 clk = ~clk;

    dpm_mailbox_ram #(.ADDR_W(AW), .DATA_W(DW), .MBOX_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n),
        .ce_l_n(ce_l_n), .oe_l_n(oe_l_n), .rw_l_n(rw_l_n), .addr_l(addr_l),
        .wdata_l(wdata_l), .rdata_l(rdata_l), .int_l_n(int_l_n),
        .ce_r_n(ce_r_n), .oe_r_n(oe_r_n), .rw_r_n(rw_r_n), .addr_r(addr_r),
        .wdata_r(wdata_r), .rdata_r(rdata_r), .int_r_n(int_r_n)
    );

    dpm_mailbox_ram #(.ADDR_W(AW), .DATA_W(DW), .MBOX_EN(1'b0)) dut_off (
        .clk(clk), .rst_n(rst_n),
        .ce_l_n(ce_l_n), .oe_l_n(oe_l_n), .rw_l_n(rw_l_n), .addr_l(addr_l),
        .wdata_l(wdata_l), .rdata_l(off_rdata_l), .int_l_n(off_int_l_n),
        .ce_r_n(ce_r_n), .oe_r_n(oe_r_n), .rw_r_n(rw_r_n), .addr_r(addr_r),
        .wdata_r(wdata_r), .rdata_r(off_rdata_r), .int_r_n(off_int_r_n)
    );

    function automatic logic [DW-1:0] pat_a(int a);
        return DW'(a * 5 + 3);
    endfunction

    function automatic logic [DW-1:0] pat_b(int a);
        return DW'(a * 7 + 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock edge, then sample just after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drv_l(input logic ce, input logic oe, input logic rw,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        ce_l_n = ce; oe_l_n = oe; rw_l_n = rw; addr_l = a; wdata_l = d;
    endtask

    task automatic drv_r(input logic ce, input logic oe, input logic rw,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        ce_r_n = ce; oe_r_n = oe; rw_r_n = rw; addr_r = a; wdata_r = d;
    endtask

    task automatic check_off_flags(input string req);
        check(req, {off_int_l_n, off_int_r_n}, 2'b11);
    endtask

    initial begin : watchdog
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        // R1: reset state
        repeat (3) tick();
        check("R1 int_l_n", int_l_n, 1);
        check("R1 int_r_n", int_r_n, 1);
        check("R1 rdata_l", rdata_l, 0);
        check("R1 rdata_r", rdata_r, 0);
        rst_n = 1'b1;
        tick();
        check("R1 flags after release", {int_l_n, int_r_n}, 2'b11);

        // R2/R9: left writes every word, right reads every word
        for (int a = 0; a < DEPTH; a++) begin
            drv_l(1'b0, 1'b1, 1'b0, AW'(a), pat_a(a));
            tick();
        end
        drv_l(1'b1, 1'b1, 1'b1, '0, '0);
        // R4 left wrote 0x7FF; R11 left wrote its own 0x7FE
        check("R4 int_r_n set", int_r_n, 0);
        check("R11 int_l_n unchanged", int_l_n, 1);
        check_off_flags("R10 after left sweep");
        for (int a = 0; a < DEPTH; a++) begin
            drv_r(1'b0, 1'b1, 1'b1, AW'(a), '0);
            tick();
            check("R2 right read", rdata_r, pat_a(a));
            check("R10 plain right read", off_rdata_r, pat_a(a));
        end
        // R6: reading 0x7FF with output enable high keeps the flag
        check("R6 oe high no clear", int_r_n, 0);

        // R2/R3: right writes every word, left reads every word
        for (int a = 0; a < DEPTH; a++) begin
            drv_r(1'b0, 1'b1, 1'b0, AW'(a), pat_b(a));
            tick();
        end
        drv_r(1'b1, 1'b1, 1'b1, '0, '0);
        check("R3 int_l_n set", int_l_n, 0);
        check_off_flags("R10 after right sweep");
        for (int a = 0; a < DEPTH; a++) begin
            drv_l(1'b0, 1'b1, 1'b1, AW'(a), '0);
            tick();
            check("R2 left read", rdata_l, pat_b(a));
            check("R10 plain left read", off_rdata_l, pat_b(a));
        end
        check("R5 oe high no clear", int_l_n, 0);

        // R5: left clears with a write to 0x7FE, output enable low
        drv_l(1'b0, 1'b0, 1'b0, BOX_L, 9'h155);
        tick();
        check("R5 clear by write", int_l_n, 1);
        drv_l(1'b1, 1'b1, 1'b1, '0, '0);
        // R9: mailbox word readable by the other port
        drv_r(1'b0, 1'b1, 1'b1, BOX_L, '0);
        tick();
        check("R9 mailbox read right", rdata_r, 9'h155);
        check("R9 plain mailbox read", off_rdata_r, 9'h155);

        // R6: right clears with a read of 0x7FF, output enable low
        drv_r(1'b0, 1'b0, 1'b1, BOX_R, '0);
        tick();
        check("R6 clear by read", int_r_n, 1);
        check("R9 mailbox read 7FF", rdata_r, pat_b(DEPTH - 1));
        drv_r(1'b1, 1'b1, 1'b1, '0, '0);
        tick();

        // R7: set and clear of the left flag at one edge
        drv_r(1'b0, 1'b1, 1'b0, BOX_L, 9'h0C3);
        drv_l(1'b0, 1'b0, 1'b1, BOX_L, '0);
        tick();
        check("R7 set wins", int_l_n, 0);
        check("R7 old data read", rdata_l, 9'h155);
        check_off_flags("R10 set/clear edge");
        drv_l(1'b1, 1'b1, 1'b1, '0, '0);
        drv_r(1'b1, 1'b1, 1'b1, '0, '0);
        tick();

        // R8: deselected ports carry write and clear patterns
        held = rdata_l;
        drv_l(1'b1, 1'b0, 1'b0, BOX_R, 9'h0AA);
        drv_r(1'b1, 1'b0, 1'b0, BOX_L, 9'h0BB);
        tick();
        tick();
        check("R8 int_l_n kept", int_l_n, 0);
        check("R8 int_r_n kept", int_r_n, 1);
        check("R8 rdata_l held", rdata_l, held);
        drv_l(1'b1, 1'b1, 1'b1, '0, '0);
        drv_r(1'b0, 1'b1, 1'b1, BOX_R, '0);
        tick();
        check("R8 no write 7FF", rdata_r, pat_b(DEPTH - 1));
        drv_r(1'b0, 1'b1, 1'b1, BOX_L, '0);
        tick();
        check("R8 no write 7FE", rdata_r, 9'h0C3);

        // R11: right writes a non-mailbox word, right writes its own box
        drv_r(1'b0, 1'b1, 1'b0, 11'h7FD, 9'h011);
        tick();
        drv_r(1'b0, 1'b1, 1'b0, BOX_R, 9'h022);
        tick();
        drv_r(1'b1, 1'b1, 1'b1, '0, '0);
        check("R11 flags unchanged", {int_l_n, int_r_n}, 2'b01);
        drv_l(1'b0, 1'b1, 1'b1, BOX_R, '0);
        tick();
        check("R9 own box write readable", rdata_l, 9'h022);
        check_off_flags("R10 final");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule